// File: doc/BRIEF.md
# Block Address Translation Lookup

This block maps a 32-bit effective address to a physical address through a small bank of block-translation register pairs. Each pair describes one aligned block of at least 128 KB. The upper word gives the block's effective index, a length field and two validity bits, one for each privilege level. The lower word gives the physical block number and a two-bit protection code. Instruction fetches look only at the first half of the bank and data accesses look only at the second half.

A request carries the effective address, an instruction/data select, a user-mode flag and a write flag. The match, the address formation and the protection decode are combinational. The result is captured into a response register, so it appears exactly one cycle after the request. Software loads the bank one 32-bit word at a time through a simple write port. The upper word of pair k sits at index 2k and the lower word at index 2k+1.

Top module: `bat_lookup`

## Requirements
- R1: Reset clears every register word and the response register. After reset, every lookup misses until the bank is programmed.
- R2: A request with `req_instr`=1 considers only pairs 0 to 3. A request with `req_instr`=0 considers only pairs 4 to 7.
- R3: A pair takes part only if it is valid for the current privilege level. Upper-word bit 0 enables it for user requests (`req_user`=1). Upper-word bit 1 enables it for supervisor requests (`req_user`=0).
- R4: The length field is upper-word bits [12:2]. The pass-through mask is that field placed at bits [27:17], with bits [16:0] set to one. The address matches when it equals upper-word bits [31:17] in every bit position where the mask is zero.
- R5: On a hit, the physical address takes the address bits where the mask is one. It takes the lower-word bits [31:17] where the mask is zero.
- R6: Lower-word bits [1:0] hold the protection code. Code 00 gives no access (`rsp_access`=00). Codes 01 and 11 give read-only (01) on a read and no access (00) on a write. Code 10 gives read-write (10).
- R7: If several pairs in the searched half match, the lowest-numbered one decides the result, even when its protection grants no access.
- R8: A miss returns `rsp_hit`=0, `rsp_pa`=0 and `rsp_access`=00.
- R9: `rsp_valid` equals `req_valid` delayed by one clock. The response fields belong to the request of the previous cycle. The response fields are all zero when `rsp_valid` is 0.
- R10: A write with `cfg_we`=1 stores `cfg_wdata` into word `cfg_idx`, where an even index is an upper word and an odd index is a lower word. Requests in later cycles see the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 4 | Register word index (pair*2 + lower) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ea | input | 32 | Effective address |
| req_instr | input | 1 | 1 = instruction access, 0 = data access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_hit | output | 1 | A pair matched |
| rsp_pa | output | 32 | Translated physical address |
| rsp_access | output | 2 | 00 none, 01 read-only, 10 read-write |

## Verification
A wrong register word or a mis-decoded length field shows on the very next response that selects that pair. It appears as a wrong physical address, a false miss, or a pair hitting in the wrong half of the bank. A priority or validity error makes a later pair's physical block appear in `rsp_pa`. That shows up one cycle after the request, because the pairs are programmed with distinct physical blocks. Protection faults show as a wrong `rsp_access` value on writes to read-only blocks.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFS_BITS = 17;   // minimum block: 128 KB
    localparam int BLEN_W   = 11;

    typedef struct packed {
        logic [ADDR_W-OFS_BITS-1:0] blk_idx;   // [31:17]
        logic [3:0]                 rsvd;      // [16:13]
        logic [BLEN_W-1:0]          blen;      // [12:2]
        logic                       sup_ok;    // [1]
        logic                       usr_ok;    // [0]
    } bat_upper_t;

    typedef struct packed {
        logic [ADDR_W-OFS_BITS-1:0] phys_blk;  // [31:17]
        logic [14:0]                rsvd;      // [16:2]
        logic [1:0]                 prot;      // [1:0]
    } bat_lower_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RO   = 2'b01,
        ACC_RW   = 2'b10
    } acc_e;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        acc_e              acc;
    } bat_rsp_t;

    // Pass-through mask built from the block-length field.
    function automatic logic [ADDR_W-1:0] offset_mask(input logic [BLEN_W-1:0] blen);
        return {{(ADDR_W-OFS_BITS-BLEN_W){1'b0}}, blen, {OFS_BITS{1'b1}}};
    endfunction

    // Protection code to access grant for this request.
    function automatic acc_e decode_prot(input logic [1:0] prot, input logic is_write);
        case (prot)
            2'b00:   return ACC_NONE;
            2'b01,
            2'b11:   return is_write ? ACC_NONE : ACC_RO;
            default: return ACC_RW;
        endcase
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    localparam int NWORDS   = 2 * NUM_PAIRS,
    localparam int IDX_W    = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wdata,
    output bat_upper_t        upper_o [NUM_PAIRS],
    output bat_lower_t        lower_o [NUM_PAIRS]
);

    logic [ADDR_W-1:0] words [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NWORDS; k++) words[k] <= '0;
        end else if (we) begin
            words[idx] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign upper_o[p] = bat_upper_t'(words[2*p]);
        assign lower_o[p] = bat_lower_t'(words[2*p+1]);
    end

    // R10: a write is visible in the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (words[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/bat_pair_match.sv
module bat_pair_match
    import bat_pkg::*;
(
    input  bat_upper_t        upper_i,
    input  bat_lower_t        lower_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              user_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic [1:0]        prot_o
);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] blk_base;
    logic [ADDR_W-1:0] phys_base;
    logic              priv_ok;
    logic              unused_bits;

    assign unused_bits = ^{upper_i.rsvd, lower_i.rsvd};

    always_comb begin
        mask      = offset_mask(upper_i.blen);
        blk_base  = {upper_i.blk_idx, {OFS_BITS{1'b0}}};
        phys_base = {lower_i.phys_blk, {OFS_BITS{1'b0}}};
        priv_ok   = user_i ? upper_i.usr_ok : upper_i.sup_ok;
        hit_o     = priv_ok && (((ea_i ^ blk_base) & ~mask) == '0);
        pa_o      = (ea_i & mask) | (phys_base & ~mask);
        prot_o    = lower_i.prot;
    end

endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick #(
    parameter int N   = 4,
    localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     hits_i,
    output logic             any_o,
    output logic [SEL_W-1:0] sel_o
);

    always_comb begin
        any_o = |hits_i;
        sel_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hits_i[k]) sel_o = SEL_W'(k);
        end
    end

endmodule

// File: rtl/bat_lookup.sv
module bat_lookup
    import bat_pkg::*;
#(
    parameter int NUM_PAIRS = 8,
    localparam int HALF     = NUM_PAIRS / 2,
    localparam int IDX_W    = $clog2(2 * NUM_PAIRS),
    localparam int PAIR_W   = $clog2(NUM_PAIRS),
    localparam int SEL_W    = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic              req_instr,
    input  logic              req_user,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [31:0]       rsp_pa,
    output logic [1:0]        rsp_access
);

    bat_upper_t        upper [NUM_PAIRS];
    bat_lower_t        lower [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] pair_hit;
    logic [ADDR_W-1:0] pair_pa   [NUM_PAIRS];
    logic [1:0]        pair_prot [NUM_PAIRS];

    logic [HALF-1:0]   half_hits;
    logic              lk_hit;
    logic [SEL_W-1:0]  sel_idx;
    logic [PAIR_W-1:0] lk_pair;
    logic [HALF-1:0]   below_mask;
    bat_rsp_t          lk_rsp;
    bat_rsp_t          rsp_q;
    logic              valid_q;

    bat_regfile #(.NUM_PAIRS(NUM_PAIRS)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .upper_o (upper),
        .lower_o (lower)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_match
        bat_pair_match match_i (
            .upper_i (upper[p]),
            .lower_i (lower[p]),
            .ea_i    (req_ea),
            .user_i  (req_user),
            .hit_o   (pair_hit[p]),
            .pa_o    (pair_pa[p]),
            .prot_o  (pair_prot[p])
        );
    end

    // Instruction side owns the low half, data side the high half.
    assign half_hits = req_instr ? pair_hit[HALF-1:0] : pair_hit[NUM_PAIRS-1:HALF];

    bat_prio_pick #(.N(HALF)) pick_i (
        .hits_i (half_hits),
        .any_o  (lk_hit),
        .sel_o  (sel_idx)
    );

    assign lk_pair    = PAIR_W'(sel_idx) + (req_instr ? PAIR_W'(0) : PAIR_W'(HALF));
    assign below_mask = ~({HALF{1'b1}} << sel_idx);

    always_comb begin
        lk_rsp = '{hit: 1'b0, pa: '0, acc: ACC_NONE};
        if (lk_hit) begin
            lk_rsp.hit = 1'b1;
            lk_rsp.pa  = pair_pa[lk_pair];
            lk_rsp.acc = decode_prot(pair_prot[lk_pair], req_write);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '{hit: 1'b0, pa: '0, acc: ACC_NONE};
        end else begin
            valid_q <= req_valid;
            rsp_q   <= req_valid ? lk_rsp : '{hit: 1'b0, pa: '0, acc: ACC_NONE};
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_pa     = rsp_q.pa;
    assign rsp_access = rsp_q.acc;

    // R2: winning pair lies in the half that matches the access kind
    a_r2_half_select: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk_hit) |->
            (pair_hit[lk_pair] &&
             (req_instr ? (lk_pair < PAIR_W'(HALF)) : (lk_pair >= PAIR_W'(HALF)))));

    // R7: no lower-numbered pair in the searched half also hit
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (req_valid && lk_hit) |-> ((half_hits & below_mask) == '0));

    // R9: response valid follows request valid by one cycle
    a_r9_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_hit && rsp_pa == '0 && rsp_access == 2'b00));

    // R8: a miss carries no address and no access
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_access == 2'b00 && rsp_pa == '0));

    // R6: a write never receives a read-only grant
    a_r6_write_not_ro: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_write)) |-> (rsp_access != 2'b01));

endmodule

// File: tb/bat_lookup_tb.sv
`timescale 1ns/1ps
module bat_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic        req_instr = 1'b0;
    logic        req_user = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_access;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    bat_lookup dut_i (
        .clk, .rst, .cfg_we, .cfg_idx, .cfg_wdata,
        .req_valid, .req_ea, .req_instr, .req_user, .req_write,
        .rsp_valid, .rsp_hit, .rsp_pa, .rsp_access
    );

    // {instr, user, write, ea, hit, pa, access}
    localparam int NV = 14;
    localparam logic [69:0] VECS [NV] = '{
        {1'b1,1'b0,1'b0,32'h1000_1234, 1'b1,32'h2000_1234,2'b10}, // R7 R5 pair0 first
        {1'b1,1'b1,1'b0,32'h1000_1234, 1'b1,32'h3000_1234,2'b01}, // R3 user skips pair0
        {1'b1,1'b1,1'b0,32'h1006_0010, 1'b1,32'h3006_0010,2'b01}, // R4 512 KB block
        {1'b1,1'b0,1'b0,32'h1006_0010, 1'b1,32'h3006_0010,2'b01}, // R4 outside 128 KB pair0
        {1'b1,1'b0,1'b1,32'h1006_0010, 1'b1,32'h3006_0010,2'b00}, // R6 write to code 01
        {1'b1,1'b1,1'b0,32'h1008_0000, 1'b0,32'h0000_0000,2'b00}, // R8 beyond block
        {1'b0,1'b1,1'b0,32'h1000_1234, 1'b1,32'h8000_1234,2'b01}, // R7 pair4 before pair5
        {1'b0,1'b1,1'b1,32'h1000_1234, 1'b1,32'h8000_1234,2'b00}, // R6 write to code 11
        {1'b0,1'b1,1'b0,32'h1ABC_DEF0, 1'b1,32'h8ABC_DEF0,2'b01}, // R4 256 MB block
        {1'b0,1'b0,1'b0,32'h1000_1234, 1'b1,32'h4000_1234,2'b00}, // R3 R6 code 00
        {1'b0,1'b0,1'b1,32'hF001_FFFF, 1'b1,32'hABCF_FFFF,2'b10}, // R5 top offset bit
        {1'b0,1'b0,1'b1,32'hF002_0000, 1'b0,32'h0000_0000,2'b00}, // R4 one past block
        {1'b0,1'b1,1'b0,32'hF000_0000, 1'b0,32'h0000_0000,2'b00}, // R3 supervisor-only
        {1'b1,1'b0,1'b0,32'hF000_0010, 1'b0,32'h0000_0000,2'b00}  // R2 data pair invisible
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic i, input logic u, input logic w, input logic [31:0] ea);
        @(negedge clk);
        req_valid = 1'b1; req_instr = i; req_user = u; req_write = w; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [63:0] rsp_word();
        return {28'd0, rsp_valid, rsp_hit, rsp_pa, rsp_access};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
        rst = 1'b0;
        lookup(1'b0, 1'b0, 1'b0, 32'h0000_0000);                  // R1 empty bank
        check("R1 empty miss", rsp_word(), {28'd0, 1'b1, 1'b0, 32'h0, 2'b00});

        wr_reg(4'd0,  32'h1000_0002); wr_reg(4'd1,  32'h2000_0002);
        wr_reg(4'd2,  32'h1000_000F); wr_reg(4'd3,  32'h3000_0001);
        wr_reg(4'd8,  32'h1000_1FFD); wr_reg(4'd9,  32'h8000_0003);
        wr_reg(4'd10, 32'h1000_0003); wr_reg(4'd11, 32'h4000_0000);
        wr_reg(4'd12, 32'hF000_0002); wr_reg(4'd13, 32'hABCE_0002);

        for (int v = 0; v < NV; v++) begin
            lookup(VECS[v][69], VECS[v][68], VECS[v][67], VECS[v][66:35]);
            checks++;
            if ({rsp_valid, rsp_hit, rsp_pa, rsp_access} !== {1'b1, VECS[v][34:0]}) begin
                errors++;
                $display("FAIL vector %0d (tag in table) actual=%h expected=%h",
                         v, {rsp_valid, rsp_hit, rsp_pa, rsp_access}, {1'b1, VECS[v][34:0]});
            end
        end

        // R9: idle cycle yields an all-zero response
        @(negedge clk);
        check("R9 idle", rsp_word(), 64'd0);

        // R9: back-to-back requests, each answered the next cycle
        @(negedge clk);
        req_valid = 1'b1; req_instr = 1'b0; req_user = 1'b0; req_write = 1'b1; req_ea = 32'hF000_0004;
        @(negedge clk);
        check("R9 first of pair", rsp_word(), {28'd0, 1'b1, 1'b1, 32'hABCE_0004, 2'b10});
        req_instr = 1'b1; req_write = 1'b0; req_ea = 32'h1000_0040;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 second of pair", rsp_word(), {28'd0, 1'b1, 1'b1, 32'h2000_0040, 2'b10});

        // R10 R7: pair0 now denies access, pair1 must not take over
        wr_reg(4'd1, 32'h2000_0000);
        lookup(1'b1, 1'b0, 1'b0, 32'h1000_1234);
        check("R10 R7 denied first pair", rsp_word(), {28'd0, 1'b1, 1'b1, 32'h2000_1234, 2'b00});

        // R10 R3: clear pair0 supervisor-valid, pair1 now answers
        wr_reg(4'd0, 32'h1000_0000);
        lookup(1'b1, 1'b0, 1'b0, 32'h1000_1234);
        check("R10 R3 pair0 disabled", rsp_word(), {28'd0, 1'b1, 1'b1, 32'h3000_1234, 2'b01});

        // R1: reset in mid-run wipes the bank
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset valid again", {63'd0, rsp_valid}, 64'd0);
        lookup(1'b0, 1'b1, 1'b0, 32'h1000_1234);
        check("R1 bank cleared", rsp_word(), {28'd0, 1'b1, 1'b0, 32'h0, 2'b00});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule